// File: doc/BRIEF.md
# Speculative Transaction Tracker with Conflict Detection

This block gives one core hardware-assisted atomic sequences over several cache lines. After a begin command, every local load records its line address in a read set, and every local store records its line in a write set and keeps its data in a private buffer. Until the sequence ends, no other agent can see those stores. Snooped accesses from remote agents are compared against both sets every cycle. If a remote access clashes with the local sets, the transaction is dropped. A commit copies every buffered line into the backing memory on a single clock edge. An abort throws the buffer away and records why it happened.

An abort has one of three causes: an explicit request from software, a conflict with a remote agent, or running out of tracking entries. The cause is reported as separate flag bits next to an 8-bit code that software supplies. When no transaction is open, loads and stores go straight to the backing memory and are not tracked. A peek port shows the backing memory exactly as a remote agent would see it.

Top module: `txn_tracker`

## Requirements
- R1: After reset the tracker is idle (`txn_active`=0), `abort_status` is 0, `abort_pulse` is 0 and every backing-memory line reads 0 on the peek port.
- R2: While idle, a store writes the backing memory at the next edge, and a load returns backing-memory data with `rsp_valid` one cycle after the command. Commit, abort and snoops issued while idle change nothing.
- R3: Command codes on `cmd_op` are 1 begin, 2 load, 3 store, 4 commit and 5 abort. Every other value is ignored. A begin issued while idle makes `txn_active` 1 after the next edge and clears `abort_status` to 0.
- R4: A store inside a transaction leaves the peek port value of its line unchanged until commit.
- R5: A load inside a transaction returns the most recent buffered data when its line is in the write buffer. Otherwise it returns backing-memory data.
- R6: A commit writes every buffered line to the backing memory on one edge, empties both sets and makes `txn_active` 0.
- R7: A conflict abort happens when a remote write hits a line in the read set or the write set, or when a remote read hits a line in the write set. A remote read of a line that is only in the read set does not abort.
- R8: After any abort, `txn_active` is 0, the buffered stores are lost, and the peek port shows the pre-transaction data.
- R9: An abort command with code C sets `abort_status` to {bit10=1, bit9=0, bit8=0, bits7:0=C}.
- R10: A load of a new line when the read set already holds RD_DEPTH lines, or a store to a new line when the write buffer already holds WR_DEPTH lines, causes an abort with bit 8 set. Repeated accesses to lines already tracked use no extra entries.
- R11: If a conflicting snoop arrives in the same cycle as a commit, the abort wins, status bit 9 is set and no line is written.
- R12: `abort_pulse` is high for exactly the one cycle after the aborting edge. `abort_status` then holds its value until the next begin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (see R3) |
| cmd_line | input | LINE_W | Line address for load or store |
| cmd_wdata | input | DATA_W | Store data |
| cmd_code | input | 8 | Code supplied with an abort command |
| snoop_valid | input | 1 | Remote access observed this cycle |
| snoop_write | input | 1 | Remote access is a write |
| snoop_line | input | LINE_W | Line address of the remote access |
| peek_line | input | LINE_W | Line to view in backing memory |
| peek_data | output | DATA_W | Backing-memory contents of peek_line (combinational) |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DATA_W | Load data |
| txn_active | output | 1 | Transaction open |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_status | output | 11 | {request, conflict, capacity, code[7:0]} |

## Verification
The bench builds the tracker with 3-bit line addresses (eight lines), 8-bit data and three entries in each set. With only eight lines, it can try every combination of read line, written line, snooped line and snoop direction, which gives 1024 short transactions. With three entries, both capacity limits are reached within a handful of accesses. Every abort code value is also applied.

// File: rtl/txn_pkg.sv
package txn_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_BEGIN  = 3'd1,
        OP_LOAD   = 3'd2,
        OP_STORE  = 3'd3,
        OP_COMMIT = 3'd4,
        OP_ABORT  = 3'd5
    } txn_op_e;

    localparam int CODE_W = 8;

    typedef struct packed {
        logic              by_request;
        logic              by_conflict;
        logic              by_capacity;
        logic [CODE_W-1:0] code;
    } abort_info_t;

    localparam int STATUS_W = $bits(abort_info_t);

    function automatic abort_info_t make_abort(input logic req, input logic conf,
                                               input logic cap, input logic [CODE_W-1:0] c);
        abort_info_t a;
        a.by_request  = req;
        a.by_conflict = conf;
        a.by_capacity = cap;
        a.code        = req ? c : '0;
        return a;
    endfunction

    // a remote read only clashes with local writes; a remote write clashes with both sets
    function automatic logic snoop_clash(input logic remote_wr, input logic in_rd, input logic in_wr);
        return in_wr | (remote_wr & in_rd);
    endfunction

endpackage

// File: rtl/txn_line_set.sv
module txn_line_set #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int DEPTH     = 4,
    parameter bit KEEP_DATA = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clear,
    input  logic                              ins_en,
    input  logic [ADDR_W-1:0]                 ins_addr,
    input  logic [DATA_W-1:0]                 ins_data,
    input  logic [ADDR_W-1:0]                 probe_addr,
    output logic                              loc_hit,
    output logic [DATA_W-1:0]                 loc_data,
    output logic                              probe_hit,
    output logic                              full,
    output logic [$clog2(DEPTH+1)-1:0]        fill,
    output logic [DEPTH-1:0]                  ent_valid,
    output logic [DEPTH-1:0][ADDR_W-1:0]      ent_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]      ent_data
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CNT_W-1:0]               count_q;
    logic [DEPTH-1:0][ADDR_W-1:0]   addr_q;
    logic [DEPTH-1:0][DATA_W-1:0]   data_q;
    logic [DEPTH-1:0]               loc_match;
    logic [DEPTH-1:0]               probe_match;
    logic [IDX_W-1:0]               hit_idx;
    logic [IDX_W-1:0]               free_idx;

    assign free_idx = count_q[IDX_W-1:0];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign ent_valid[g]   = (count_q > CNT_W'(g));
        assign loc_match[g]   = ent_valid[g] && (addr_q[g] == ins_addr);
        assign probe_match[g] = ent_valid[g] && (addr_q[g] == probe_addr);
    end

    assign loc_hit   = |loc_match;
    assign probe_hit = |probe_match;
    assign full      = (count_q == CNT_W'(DEPTH));
    assign fill      = count_q;
    assign ent_addr  = addr_q;
    assign ent_data  = data_q;

    always_comb begin
        hit_idx  = '0;
        loc_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (loc_match[i]) begin
                hit_idx  = IDX_W'(i);
                loc_data = loc_data | data_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count_q <= '0;
        end else if (ins_en && !loc_hit && !full) begin
            addr_q[free_idx] <= ins_addr;
            count_q          <= count_q + CNT_W'(1);
        end
    end

    if (KEEP_DATA) begin : g_data
        always_ff @(posedge clk) begin
            if (ins_en && !clear) begin
                if (loc_hit)
                    data_q[hit_idx] <= ins_data;
                else if (!full)
                    data_q[free_idx] <= ins_data;
            end
        end
    end else begin : g_nodata
        logic unused_ins_data;
        assign unused_ins_data = ^ins_data;
        assign data_q = '0;
    end

    // a line is never tracked twice, so a lookup sees at most one entry
    p_one_match_r5: assert property (@(posedge clk) disable iff (rst)
        $countones(loc_match) <= 1);

    p_probe_unique_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(probe_match) <= 1);

endmodule

// File: rtl/txn_backing_store.sv
module txn_backing_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int PORTS  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             waddr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          bulk_en,
    input  logic [PORTS-1:0]              bulk_valid,
    input  logic [PORTS-1:0][ADDR_W-1:0]  bulk_addr,
    input  logic [PORTS-1:0][DATA_W-1:0]  bulk_data,
    input  logic [ADDR_W-1:0]             raddr_a,
    output logic [DATA_W-1:0]             rdata_a,
    input  logic [ADDR_W-1:0]             raddr_b,
    output logic [DATA_W-1:0]             rdata_b
);
    localparam int LINES = 1 << ADDR_W;

    logic [LINES-1:0][DATA_W-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            if (we)
                mem_q[waddr] <= wdata;
            if (bulk_en) begin
                for (int p = 0; p < PORTS; p++) begin
                    if (bulk_valid[p])
                        mem_q[bulk_addr[p]] <= bulk_data[p];
                end
            end
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    // direct stores happen only outside a transaction, publishing only at its end
    p_one_writer_r6: assert property (@(posedge clk) disable iff (rst)
        bulk_en |-> !we);

endmodule

// File: rtl/txn_tracker.sv
module txn_tracker import txn_pkg::*; #(
    parameter int LINE_W   = 4,
    parameter int DATA_W   = 8,
    parameter int RD_DEPTH = 4,
    parameter int WR_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [LINE_W-1:0]    cmd_line,
    input  logic [DATA_W-1:0]    cmd_wdata,
    input  logic [CODE_W-1:0]    cmd_code,
    input  logic                 snoop_valid,
    input  logic                 snoop_write,
    input  logic [LINE_W-1:0]    snoop_line,
    input  logic [LINE_W-1:0]    peek_line,
    output logic [DATA_W-1:0]    peek_data,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_data,
    output logic                 txn_active,
    output logic                 abort_pulse,
    output logic [STATUS_W-1:0]  abort_status
);
    localparam int RD_CNT_W = $clog2(RD_DEPTH+1);
    localparam int WR_CNT_W = $clog2(WR_DEPTH+1);

    txn_op_e op;
    logic is_begin, is_load, is_store, is_commit, is_abort;
    logic active_q, pulse_q, rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;
    abort_info_t status_q;

    logic conflict_now, capacity_now, request_now, abort_now, commit_now, start_now;
    logic sets_clear;

    logic rd_loc_hit, rd_probe_hit, rd_full;
    logic wr_loc_hit, wr_probe_hit, wr_full;
    logic [DATA_W-1:0] wr_loc_data, mem_rdata;
    logic [RD_CNT_W-1:0] rd_fill;
    logic [WR_CNT_W-1:0] wr_fill;
    logic [DATA_W-1:0] rd_unused_data;
    logic [RD_DEPTH-1:0] rd_unused_valid;
    logic [RD_DEPTH-1:0][LINE_W-1:0] rd_unused_addr;
    logic [RD_DEPTH-1:0][DATA_W-1:0] rd_unused_ent;
    logic [WR_DEPTH-1:0] wr_valid;
    logic [WR_DEPTH-1:0][LINE_W-1:0] wr_addr;
    logic [WR_DEPTH-1:0][DATA_W-1:0] wr_data;

    assign op        = txn_op_e'(cmd_op);
    assign is_begin  = cmd_valid && (op == OP_BEGIN);
    assign is_load   = cmd_valid && (op == OP_LOAD);
    assign is_store  = cmd_valid && (op == OP_STORE);
    assign is_commit = cmd_valid && (op == OP_COMMIT);
    assign is_abort  = cmd_valid && (op == OP_ABORT);

    // abort causes, all judged against the sets as they stood before this edge
    assign conflict_now = active_q && snoop_valid &&
                          snoop_clash(snoop_write, rd_probe_hit, wr_probe_hit);
    assign capacity_now = active_q && ((is_load  && !rd_loc_hit && rd_full) ||
                                       (is_store && !wr_loc_hit && wr_full));
    assign request_now  = active_q && is_abort;
    assign abort_now    = conflict_now || capacity_now || request_now;
    assign commit_now   = active_q && is_commit && !abort_now;
    assign start_now    = !active_q && is_begin;
    assign sets_clear   = abort_now || commit_now || start_now;

    txn_line_set #(
        .ADDR_W(LINE_W), .DATA_W(DATA_W), .DEPTH(RD_DEPTH), .KEEP_DATA(1'b0)
    ) u_read_set (
        .clk(clk), .rst(rst), .clear(sets_clear),
        .ins_en(active_q && is_load && !abort_now),
        .ins_addr(cmd_line), .ins_data(cmd_wdata), .probe_addr(snoop_line),
        .loc_hit(rd_loc_hit), .loc_data(rd_unused_data), .probe_hit(rd_probe_hit),
        .full(rd_full), .fill(rd_fill), .ent_valid(rd_unused_valid),
        .ent_addr(rd_unused_addr), .ent_data(rd_unused_ent)
    );

    txn_line_set #(
        .ADDR_W(LINE_W), .DATA_W(DATA_W), .DEPTH(WR_DEPTH), .KEEP_DATA(1'b1)
    ) u_write_buf (
        .clk(clk), .rst(rst), .clear(sets_clear),
        .ins_en(active_q && is_store && !abort_now),
        .ins_addr(cmd_line), .ins_data(cmd_wdata), .probe_addr(snoop_line),
        .loc_hit(wr_loc_hit), .loc_data(wr_loc_data), .probe_hit(wr_probe_hit),
        .full(wr_full), .fill(wr_fill), .ent_valid(wr_valid),
        .ent_addr(wr_addr), .ent_data(wr_data)
    );

    txn_backing_store #(
        .ADDR_W(LINE_W), .DATA_W(DATA_W), .PORTS(WR_DEPTH)
    ) u_store (
        .clk(clk), .rst(rst),
        .we(!active_q && is_store), .waddr(cmd_line), .wdata(cmd_wdata),
        .bulk_en(commit_now), .bulk_valid(wr_valid), .bulk_addr(wr_addr), .bulk_data(wr_data),
        .raddr_a(cmd_line), .rdata_a(mem_rdata),
        .raddr_b(peek_line), .rdata_b(peek_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= 1'b0;
            pulse_q     <= 1'b0;
            status_q    <= '0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            pulse_q     <= abort_now;
            rsp_valid_q <= is_load;
            if (is_load)
                rsp_data_q <= (active_q && wr_loc_hit) ? wr_loc_data : mem_rdata;
            if (start_now) begin
                active_q <= 1'b1;
                status_q <= '0;
            end else if (abort_now) begin
                active_q <= 1'b0;
                status_q <= make_abort(request_now, conflict_now, capacity_now, cmd_code);
            end else if (commit_now) begin
                active_q <= 1'b0;
            end
        end
    end

    assign txn_active   = active_q;
    assign abort_pulse  = pulse_q;
    assign abort_status = status_q;
    assign rsp_valid    = rsp_valid_q;
    assign rsp_data     = rsp_data_q;

    p_abort_drops_r8: assert property (@(posedge clk) disable iff (rst)
        abort_now |=> (!txn_active && wr_fill == '0 && rd_fill == '0));

    p_commit_empties_r6: assert property (@(posedge clk) disable iff (rst)
        commit_now |=> (!txn_active && wr_fill == '0 && rd_fill == '0));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !is_begin) |=> (!txn_active && $stable(abort_status)));

    p_shared_read_ok_r7: assert property (@(posedge clk) disable iff (rst)
        (active_q && snoop_valid && !snoop_write && !wr_probe_hit && !is_abort && !capacity_now)
        |=> !abort_pulse);

    p_status_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!abort_now && !start_now) |=> $stable(abort_status));

endmodule

// File: tb/txn_tracker_bench.sv
`timescale 1ns/1ps
module txn_tracker_bench;
    import txn_pkg::*;

    localparam int LW = 3;
    localparam int DW = 8;
    localparam int RD = 3;
    localparam int WR = 3;
    localparam int LINES = 1 << LW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [LW-1:0] cmd_line = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [7:0] cmd_code = '0;
    logic snoop_valid = 1'b0, snoop_write = 1'b0;
    logic [LW-1:0] snoop_line = '0;
    logic [LW-1:0] peek_line = '0;
    logic [DW-1:0] peek_data, rsp_data;
    logic rsp_valid, txn_active, abort_pulse;
    logic [STATUS_W-1:0] abort_status;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [LINES];

    always #4 clk = ~clk;

    txn_tracker #(.LINE_W(LW), .DATA_W(DW), .RD_DEPTH(RD), .WR_DEPTH(WR)) u_txn_tracker (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
        .cmd_wdata(cmd_wdata), .cmd_code(cmd_code), .snoop_valid(snoop_valid),
        .snoop_write(snoop_write), .snoop_line(snoop_line), .peek_line(peek_line),
        .peek_data(peek_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .txn_active(txn_active), .abort_pulse(abort_pulse), .abort_status(abort_status)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input txn_op_e op, input int line, input int data, input int code);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_line  = LW'(line);
        cmd_wdata = DW'(data);
        cmd_code  = 8'(code);
        tick();
        cmd_valid = 1'b0;
        cmd_op    = OP_NOP;
    endtask

    task automatic peek_chk(input string tag, input int line, input int exp);
        peek_line = LW'(line);
        #1;
        chk(tag, int'(peek_data), exp);
    endtask

    task automatic peek_all(input string tag);
        for (int i = 0; i < LINES; i++) peek_chk(tag, i, int'(model[i]));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) model[i] = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 active", int'(txn_active), 0);
        chk("R1 status", int'(abort_status), 0);
        chk("R1 pulse", int'(abort_pulse), 0);
        peek_all("R1 mem");

        // R2 untracked access
        for (int i = 0; i < LINES; i++) begin
            send(OP_STORE, i, i * 17 + 3, 0);
            model[i] = DW'(i * 17 + 3);
        end
        peek_all("R2 direct store");
        for (int i = 0; i < LINES; i++) begin
            send(OP_LOAD, i, 0, 0);
            chk("R2 rsp_valid", int'(rsp_valid), 1);
            chk("R2 rsp_data", int'(rsp_data), int'(model[i]));
        end
        tick();
        chk("R2 rsp_valid low", int'(rsp_valid), 0);
        snoop_valid = 1'b1; snoop_write = 1'b1; snoop_line = 3'd2;
        send(OP_ABORT, 0, 0, 8'h33);
        snoop_valid = 1'b0;
        chk("R2 idle abort pulse", int'(abort_pulse), 0);
        chk("R2 idle abort status", int'(abort_status), 0);
        send(OP_COMMIT, 0, 0, 0);
        chk("R2 idle commit active", int'(txn_active), 0);
        send(txn_op_e'(3'd7), 1, 8'hEE, 0);
        chk("R3 bad op active", int'(txn_active), 0);
        peek_all("R3 bad op mem");

        // R3 R4 R5 R6 basic transaction
        send(OP_BEGIN, 0, 0, 0);
        chk("R3 begin active", int'(txn_active), 1);
        send(OP_STORE, 1, 8'hA1, 0);
        send(OP_STORE, 4, 8'hB4, 0);
        send(OP_STORE, 1, 8'hC1, 0);
        peek_chk("R4 hidden line1", 1, int'(model[1]));
        peek_chk("R4 hidden line4", 4, int'(model[4]));
        send(OP_LOAD, 1, 0, 0);
        chk("R5 buffered load", int'(rsp_data), 8'hC1);
        send(OP_LOAD, 6, 0, 0);
        chk("R5 unbuffered load", int'(rsp_data), int'(model[6]));
        send(OP_COMMIT, 0, 0, 0);
        model[1] = 8'hC1; model[4] = 8'hB4;
        chk("R6 commit inactive", int'(txn_active), 0);
        chk("R6 commit no pulse", int'(abort_pulse), 0);
        peek_all("R6 commit mem");

        // R7 R8 sweep of read line, written line, snoop line, snoop kind
        for (int ra = 0; ra < LINES; ra++)
            for (int wa = 0; wa < LINES; wa++)
                for (int sa = 0; sa < LINES; sa++)
                    for (int sw = 0; sw < 2; sw++) begin
                        automatic int val = (ra * 64 + wa * 8 + sa + sw * 37) & 8'hFF;
                        automatic bit clash = (sa == wa) || (sw == 1 && sa == ra);
                        send(OP_BEGIN, 0, 0, 0);
                        send(OP_LOAD, ra, 0, 0);
                        chk("R5 sweep load", int'(rsp_data), int'(model[ra]));
                        send(OP_STORE, wa, val, 0);
                        snoop_valid = 1'b1; snoop_write = sw[0]; snoop_line = LW'(sa);
                        tick();
                        snoop_valid = 1'b0;
                        chk("R7 conflict pulse", int'(abort_pulse), int'(clash));
                        if (clash) begin
                            chk("R7 conflict status", int'(abort_status), 'h200);
                            chk("R8 inactive", int'(txn_active), 0);
                            peek_chk("R8 discarded", wa, int'(model[wa]));
                        end else begin
                            peek_chk("R4 sweep hidden", wa, int'(model[wa]));
                            send(OP_COMMIT, 0, 0, 0);
                            model[wa] = DW'(val);
                            peek_chk("R6 sweep commit", wa, val);
                        end
                    end

        // R9 R12 explicit abort for every code
        for (int c = 0; c < 256; c++) begin
            send(OP_BEGIN, 0, 0, 0);
            chk("R12 begin clears", int'(abort_status), 0);
            send(OP_STORE, c % LINES, c ^ 8'h5A, 0);
            send(OP_ABORT, 0, 0, c);
            chk("R9 pulse", int'(abort_pulse), 1);
            chk("R9 status", int'(abort_status), 'h400 | c);
            tick();
            chk("R12 pulse one cycle", int'(abort_pulse), 0);
            chk("R12 status held", int'(abort_status), 'h400 | c);
            peek_chk("R8 explicit discard", c % LINES, int'(model[c % LINES]));
        end

        // R10 read-set capacity
        send(OP_BEGIN, 0, 0, 0);
        send(OP_LOAD, 0, 0, 0);
        send(OP_LOAD, 1, 0, 0);
        send(OP_LOAD, 2, 0, 0);
        send(OP_LOAD, 1, 0, 0);
        chk("R10 repeat read ok", int'(txn_active), 1);
        send(OP_LOAD, 3, 0, 0);
        chk("R10 read capacity pulse", int'(abort_pulse), 1);
        chk("R10 read capacity status", int'(abort_status), 'h100);
        // R10 write-buffer capacity
        send(OP_BEGIN, 0, 0, 0);
        send(OP_STORE, 4, 8'h44, 0);
        send(OP_STORE, 5, 8'h55, 0);
        send(OP_STORE, 6, 8'h66, 0);
        send(OP_STORE, 5, 8'h57, 0);
        chk("R10 repeat write ok", int'(txn_active), 1);
        send(OP_STORE, 7, 8'h77, 0);
        chk("R10 write capacity status", int'(abort_status), 'h100);
        peek_all("R8 capacity discard");
        // full buffer commits cleanly
        send(OP_BEGIN, 0, 0, 0);
        send(OP_STORE, 0, 8'h10, 0);
        send(OP_STORE, 1, 8'h11, 0);
        send(OP_STORE, 2, 8'h12, 0);
        send(OP_STORE, 1, 8'h19, 0);
        send(OP_LOAD, 1, 0, 0);
        chk("R5 full buffer load", int'(rsp_data), 8'h19);
        send(OP_COMMIT, 0, 0, 0);
        model[0] = 8'h10; model[1] = 8'h19; model[2] = 8'h12;
        peek_all("R6 full commit");

        // R11 conflict beats commit
        send(OP_BEGIN, 0, 0, 0);
        send(OP_STORE, 2, 8'hD2, 0);
        snoop_valid = 1'b1; snoop_write = 1'b0; snoop_line = 3'd2;
        send(OP_COMMIT, 0, 0, 0);
        snoop_valid = 1'b0;
        chk("R11 pulse", int'(abort_pulse), 1);
        chk("R11 status", int'(abort_status), 'h200);
        chk("R11 inactive", int'(txn_active), 0);
        peek_all("R11 mem unchanged");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule